// File: doc/BRIEF.md
# Cache Write Policy Controller

This block holds the write-policy configuration of a level-one data cache and decides, for every cacheable store, how that store is handled. From a one-bit write-mode field and a two-bit allocate field it works out whether the store goes write-through or copy-back, whether a miss pulls a new line into the cache, and whether the store bytes may fold into a linefill buffer that is already being filled. Every decision output is combinational from the register contents and the inputs of the current access.

The same register also carries two sticky status flags. One records that a snoop invalidation removed a locked line. The other records that a lock request failed for a reason other than overflow. Hardware event pulses set the flags. Software clears a flag by writing 0 to its bit, and writing 1 to it leaves the flag unchanged. The register is written through a single write port and read back on a parallel output.

Top module: `cwp_top`

## Requirements
- R1: After reset the whole readback word `regRdData` is 0.
- R2: When the write-mode bit (bit 0) is 0, every store drives `isWriteThrough`=1 and `isCopyBack`=0, whatever the value of `pageWt`.
- R3: When the write-mode bit is 1, a store is copy-back (`isCopyBack`=1) if `pageWt`=0 and write-through (`isWriteThrough`=1) if `pageWt`=1.
- R4: When the allocate field (bits 2:1) is 00, or the reserved value 11, `allocLine` stays 0.
- R5: When the allocate field is 01, `allocLine` is 1 only for a store that misses and resolves to copy-back.
- R6: When the allocate field is 10, `allocLine` is 1 for every store that misses. `allocLine` is always 0 on a hit.
- R7: `mergeFill` is 1 for a store during a busy linefill exactly when the allocate field is 01 or 10, for either write type.
- R8: The snoop-lock flag (bit 4) is set on the clock edge after `snoopLockEvt`. It holds until a register write carries 0 in bit 4. A write carrying 1 in bit 4 leaves it unchanged.
- R9: The unable-to-lock flag (bit 5) follows the same rules as R8, with `lockFailEvt` as the set event.
- R10: A set event and a clearing write to the same flag in the same cycle leave the flag set.
- R11: A register write loads bits 0 and 2:1 from `regWrData`. All bits other than 0, 2:1, 4 and 5 read as 0.
- R12: While `storeValid` is 0, all four decision outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register readback |
| storeValid | input | 1 | A cacheable store is presented this cycle |
| accHit | input | 1 | The store hits in the cache |
| pageWt | input | 1 | Page write-through attribute of the store |
| fillBusy | input | 1 | A linefill is in progress |
| snoopLockEvt | input | 1 | Pulse: a snoop invalidated a locked line |
| lockFailEvt | input | 1 | Pulse: a lock request failed, not by overflow |
| isWriteThrough | output | 1 | Store handled write-through |
| isCopyBack | output | 1 | Store handled copy-back |
| allocLine | output | 1 | Miss allocates a line |
| mergeFill | output | 1 | Store data merges into the linefill buffer |

## Verification
Random stores are applied under all four allocate values and both write modes, with the page attribute, hit and linefill inputs drawn independently. This separates a decoder that ignores `pageWt` in write-through mode from one that lets it leak through, and an allocate decoder that checks the resolved write type from one that looks only at the field. Random register writes overlap with random event pulses, so set-and-clear collisions and writes of 1 to the flags occur alongside directed cases. The directed cases cover each flag's set, hold, ignored write of 1 and clear by 0.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  localparam int REG_W     = 32;
  localparam int MODE_BIT  = 0;
  localparam int ALLOC_LO  = 1;
  localparam int ALLOC_W   = 2;
  localparam int SLC_BIT   = 4;
  localparam int UTL_BIT   = 5;

  typedef enum logic [ALLOC_W-1:0] {
    ALLOC_NONE = 2'b00,
    ALLOC_CB   = 2'b01,
    ALLOC_ALL  = 2'b10,
    ALLOC_RSVD = 2'b11
  } alloc_e;

  typedef struct packed {
    logic cfgLoad;
    logic slcSet;
    logic slcClr;
    logic utlSet;
    logic utlClr;
  } strobe_t;
endpackage

// File: rtl/cwp_regs.sv
module cwp_regs
  import cwp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [REG_W-1:0] wrData,
  output logic             modeQ,
  output alloc_e           allocQ,
  output logic [REG_W-1:0] rdData
);
  logic slcQ, utlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= 1'b0;
      allocQ <= ALLOC_NONE;
      slcQ   <= 1'b0;
      utlQ   <= 1'b0;
    end else begin
      if (strobe.cfgLoad) begin
        modeQ  <= wrData[MODE_BIT];
        allocQ <= alloc_e'(wrData[ALLOC_LO +: ALLOC_W]);
      end
      slcQ <= strobe.slcSet | (slcQ & ~strobe.slcClr);
      utlQ <= strobe.utlSet | (utlQ & ~strobe.utlClr);
    end
  end

  always_comb begin
    rdData                       = '0;
    rdData[MODE_BIT]             = modeQ;
    rdData[ALLOC_LO +: ALLOC_W]  = allocQ;
    rdData[SLC_BIT]              = slcQ;
    rdData[UTL_BIT]              = utlQ;
  end
endmodule

// File: rtl/cwp_policy.sv
module cwp_policy
  import cwp_pkg::*;
(
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             snoopLockEvt,
  input  logic             lockFailEvt,
  input  logic             modeQ,
  input  alloc_e           allocQ,
  input  logic             storeValid,
  input  logic             accHit,
  input  logic             pageWt,
  input  logic             fillBusy,
  output strobe_t          strobe,
  output logic             isWriteThrough,
  output logic             isCopyBack,
  output logic             allocLine,
  output logic             mergeFill
);
  logic copyBackRes;
  logic allocOk;
  logic fieldLive;

  always_comb begin
    strobe.cfgLoad = regWrEn;
    strobe.slcSet  = snoopLockEvt;
    strobe.slcClr  = regWrEn & ~regWrData[SLC_BIT];
    strobe.utlSet  = lockFailEvt;
    strobe.utlClr  = regWrEn & ~regWrData[UTL_BIT];
  end

  always_comb begin
    copyBackRes = modeQ & ~pageWt;
    unique case (allocQ)
      ALLOC_CB:  begin allocOk = copyBackRes; fieldLive = 1'b1; end
      ALLOC_ALL: begin allocOk = 1'b1;        fieldLive = 1'b1; end
      default:   begin allocOk = 1'b0;        fieldLive = 1'b0; end
    endcase
    isCopyBack     = storeValid & copyBackRes;
    isWriteThrough = storeValid & ~copyBackRes;
    allocLine      = storeValid & ~accHit & allocOk;
    mergeFill      = storeValid & fillBusy & fieldLive;
  end
endmodule

// File: rtl/cwp_top.sv
module cwp_top
  import cwp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             storeValid,
  input  logic             accHit,
  input  logic             pageWt,
  input  logic             fillBusy,
  input  logic             snoopLockEvt,
  input  logic             lockFailEvt,
  output logic             isWriteThrough,
  output logic             isCopyBack,
  output logic             allocLine,
  output logic             mergeFill
);
  strobe_t strobe;
  logic    modeQ;
  alloc_e  allocQ;

  cwp_regs u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .modeQ(modeQ), .allocQ(allocQ), .rdData(regRdData)
  );

  cwp_policy u_policy (
    .regWrEn(regWrEn), .regWrData(regWrData),
    .snoopLockEvt(snoopLockEvt), .lockFailEvt(lockFailEvt),
    .modeQ(modeQ), .allocQ(allocQ),
    .storeValid(storeValid), .accHit(accHit), .pageWt(pageWt), .fillBusy(fillBusy),
    .strobe(strobe),
    .isWriteThrough(isWriteThrough), .isCopyBack(isCopyBack),
    .allocLine(allocLine), .mergeFill(mergeFill)
  );
endmodule

// File: rtl/cwp_checker.sv
module cwp_checker
  import cwp_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] regRdData,
  input logic             storeValid,
  input logic             accHit,
  input logic             pageWt,
  input logic             fillBusy,
  input logic             snoopLockEvt,
  input logic             lockFailEvt,
  input logic             isWriteThrough,
  input logic             isCopyBack,
  input logic             allocLine,
  input logic             mergeFill
);
  logic [ALLOC_W-1:0] allocRd;
  logic [REG_W-1:0]   liveMask;
  assign allocRd  = regRdData[ALLOC_LO +: ALLOC_W];
  always_comb begin
    liveMask = '0;
    liveMask[MODE_BIT] = 1'b1;
    liveMask[ALLOC_LO +: ALLOC_W] = '1;
    liveMask[SLC_BIT] = 1'b1;
    liveMask[UTL_BIT] = 1'b1;
  end

  p_wt_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && !regRdData[MODE_BIT]) |-> (isWriteThrough && !isCopyBack));
  p_pagewt_r3: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && regRdData[MODE_BIT] && pageWt) |-> (isWriteThrough && !isCopyBack));
  p_alloc_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (allocRd == 2'b00 || allocRd == 2'b11) |-> !allocLine);
  p_no_alloc_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    accHit |-> !allocLine);
  p_no_merge_r7: assert property (@(posedge clk) disable iff (!rstN)
    (allocRd == 2'b00) |-> !mergeFill);
  p_slc_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    snoopLockEvt |=> regRdData[SLC_BIT]);
  p_utl_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    lockFailEvt |=> regRdData[UTL_BIT]);
  p_slc_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[SLC_BIT] && !(regWrEn && !regWrData[SLC_BIT])) |=> regRdData[SLC_BIT]);
  p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & ~liveMask) == '0);
  p_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !storeValid |-> !(isWriteThrough || isCopyBack || allocLine || mergeFill));
endmodule

bind cwp_top cwp_checker u_cwp_checker (.*);

// File: tb/cwp_top_bench.sv
`timescale 1ns/1ps
module cwp_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        storeValid = 1'b0, accHit = 1'b0, pageWt = 1'b0, fillBusy = 1'b0;
  logic        snoopLockEvt = 1'b0, lockFailEvt = 1'b0;
  logic        isWriteThrough, isCopyBack, allocLine, mergeFill;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic       mMode = 1'b0;
  logic [1:0] mAlloc = 2'b00;
  logic       mSlc = 1'b0, mUtl = 1'b0;

  always #2 clk = ~clk;

  cwp_top u_cwp_top (.*);

  function automatic logic [31:0] expRd();
    logic [31:0] v = '0;
    v[0] = mMode; v[2:1] = mAlloc; v[4] = mSlc; v[5] = mUtl;
    return v;
  endfunction
  function automatic logic expCb(); return storeValid & mMode & ~pageWt; endfunction
  function automatic logic expWt(); return storeValid & ~(mMode & ~pageWt); endfunction
  function automatic logic expAlloc();
    if (!storeValid || accHit) return 1'b0;
    if (mAlloc == 2'b01) return mMode & ~pageWt;
    return mAlloc == 2'b10;
  endfunction
  function automatic logic expMerge();
    return storeValid & fillBusy & (mAlloc == 2'b01 || mAlloc == 2'b10);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    string wtTag = mMode ? "R3" : "R2";
    string alTag = (mAlloc == 2'b01) ? "R5" : (mAlloc == 2'b10) ? "R6" : "R4";
    if (!storeValid) begin wtTag = "R12"; alTag = "R12"; end
    check({wtTag, " writeThrough"}, 32'(isWriteThrough), 32'(expWt()));
    check({wtTag, " copyBack"}, 32'(isCopyBack), 32'(expCb()));
    check({alTag, " allocLine"}, 32'(allocLine), 32'(expAlloc()));
    check(storeValid ? "R7 mergeFill" : "R12 mergeFill", 32'(mergeFill), 32'(expMerge()));
    check("R8 R9 R10 R11 readback", regRdData, expRd());
  endtask

  // one cycle: drive at negedge, check, then model the edge
  task automatic step(logic we, logic [31:0] wd, logic sv, logic hit, logic pw,
                      logic fb, logic se, logic le);
    @(negedge clk);
    regWrEn = we; regWrData = wd; storeValid = sv; accHit = hit; pageWt = pw;
    fillBusy = fb; snoopLockEvt = se; lockFailEvt = le;
    #1 checkAll();
    @(posedge clk);
    if (we) begin mMode = wd[0]; mAlloc = wd[2:1]; end
    mSlc = se | (mSlc & ~(we & ~wd[4]));
    mUtl = le | (mUtl & ~(we & ~wd[5]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #1 check("R1 reset readback", regRdData, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1 check("R1 readback after release", regRdData, 32'h0);
    // R2: write-through mode ignores pageWt
    step(0, 0, 1, 0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    // R3 / R5: copy-back, allocate on copy-back miss only
    step(1, 32'h3, 1, 0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 1, 1, 0, 0);
    // R6 / R4: allocate-all, then reserved 11, with all-ones junk in reserved bits (R11)
    step(1, 32'hFFFF_FFC5, 1, 0, 1, 1, 0, 0);
    step(1, 32'hFFFF_FFFF, 1, 0, 0, 1, 0, 0);
    step(0, 0, 1, 1, 0, 1, 0, 0);
    // R8 / R9: set, hold, write-1 ignored, clear by 0
    step(0, 0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 32'h30, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 32'h00, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    // R10: set and clear in the same cycle
    step(1, 32'h00, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 32'h10, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic we = ($urandom % 4) == 0;
      step(we, $urandom, ($urandom % 4) != 0, $urandom % 2, $urandom % 2,
           $urandom % 2, ($urandom % 8) == 0, ($urandom % 8) == 0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule